// File: doc/BRIEF.md
# Write Data Hold Extender

This block sits between a processor-style bus and a buffered data bus that feeds a RAM. Its job is to keep the write data on that bus after the processor ends its write. Without it, the data could vanish before the RAM's hold time is met. The bus strobe E is treated as a data input and is sampled by a faster system clock. All state changes on that clock.

A single state bit records whether the block is in the write state or the idle state. While E is high and the processor drives the read/write line low, the block enters the write state. A data register then follows the processor byte on every system clock, which makes it transparent at clock granularity, and the bus output enable turns on. When E falls, the register stops following and keeps the last byte. The state bit returns to idle only on the next rising edge of E, and only if the read/write line is high by then. As a result, the bus keeps driving the captured byte for one whole E-low half period after the write ends. No separate timer is used.

The same state bit produces delayed read and write strobes, each in active-high and active-low form, for downstream buffers and latches.

Top module: `wr_hold_extender`

## Requirements
- R1: With `rst_n` low at a clock edge, the block returns to the idle state after that edge. Idle means `bus_oe` is 0, `rd_dly` is 1 and `wr_dly` is 0.
- R2: A clock edge that sees `e_clk` = 1 and `rnw` = 0 puts the block in the write state after that edge, with `bus_oe` = 1. This holds whatever the prior state was.
- R3: At each clock edge that sees `e_clk` = 1 and `rnw` = 0, `bus_data` takes the value `cpu_data` had at that edge. `bus_data` therefore follows the processor byte with one clock of lag while E is high.
- R4: At any edge that sees `e_clk` = 0, `bus_data` keeps its value, whatever `cpu_data` does.
- R5: Once a write has ended, `bus_oe` stays 1 through the whole E-low phase. It drops at the first edge that sees a rising E with `rnw` = 1. The hold extension is therefore one E half period, for any half-period length.
- R6: A bus cycle with `rnw` = 1 throughout never asserts `bus_oe`.
- R7: Back-to-back writes, with `rnw` held low through the E-low phase between them, keep `bus_oe` at 1. During that low phase `bus_data` shows the first byte, and it switches to the second byte at the first edge where E is high again.
- R8: The strobes follow the state bit. `wr_dly` = `bus_oe`, `wr_dly_n` = NOT `bus_oe`, `rd_dly` = NOT `bus_oe`, and `rd_dly_n` = `bus_oe`.
- R9: A reset edge that falls in the middle of a write releases the bus at once. The next edge that sees E high with `rnw` low re-enters the write state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| e_clk | input | 1 | Bus strobe E, synchronous to `clk` |
| rnw | input | 1 | Read/write line, 1 = read, 0 = write |
| cpu_data | input | DATA_W | Processor write byte |
| bus_data | output | DATA_W | Data presented to the buffered bus |
| bus_oe | output | 1 | Drive enable for `bus_data` onto the buffered bus |
| rd_dly | output | 1 | Delayed read strobe, active high |
| rd_dly_n | output | 1 | Delayed read strobe, active low |
| wr_dly | output | 1 | Delayed write strobe, active high |
| wr_dly_n | output | 1 | Delayed write strobe, active low |

## Verification
The bench builds the block with `DATA_W` = 12 rather than the default 8. This shows that no part of the data path depends on a byte width. It drives E with two half-period lengths, 3 and 6 system clocks, which shows that the extension tracks E rather than a fixed count. The buffered bus is modelled as a shared tri-state wire, so the bench sees a high-impedance value whenever the drive enable is off. The scenarios are:
- a write whose byte changes while E is high;
- back-to-back writes;
- a read-only cycle;
- a reset in the middle of a write.

// File: rtl/weh_pkg.sv
// Package: shared types and helpers for the write data hold extender.
// Assumes nothing beyond a single state bit where 1 means idle/read
// and 0 means write.
package weh_pkg;

    // Four strobe outputs derived from the delay state bit
    typedef struct packed {
        logic rd;
        logic rd_n;
        logic wr;
        logic wr_n;
    } weh_strobe_t;

    // Build both polarities of both strobes from the state bit
    function automatic weh_strobe_t weh_make_strobes(input logic idle_q);
        weh_strobe_t s;
        s.rd   = idle_q;
        s.rd_n = ~idle_q;
        s.wr   = ~idle_q;
        s.wr_n = idle_q;
        return s;
    endfunction

endpackage

// File: rtl/weh_edge.sv
// Module: weh_edge
// Detects rising edges of the bus strobe E, which is sampled by the
// system clock. Assumes E is already synchronous to clk. Reset loads
// the history bit with 1, so no rising edge is reported in the first
// cycle after reset.
module weh_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic e_in,
    output logic e_rise
);

    logic e_prev;

    // Keep the value of E seen at the previous clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) e_prev <= 1'b1;
        else        e_prev <= e_in;
    end

    assign e_rise = e_in & ~e_prev;

endmodule

// File: rtl/weh_delay_ff.sv
// Module: weh_delay_ff
// The delay state bit. idle_q = 1 means idle/read (bus released) and
// 0 means write. A write with E high forces the bit to 0 at once. The
// bit samples rnw only on rising E, so it goes back to 1 half an E
// cycle after a write ends. Reset forces idle.
module weh_delay_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic e_in,
    input  logic e_rise,
    input  logic rnw,
    output logic idle_q
);

    logic force_wr;
    assign force_wr = ~rnw & e_in;

    // State bit: forced write has priority over sampling on rising E
    always_ff @(posedge clk) begin
        if (!rst_n)        idle_q <= 1'b1;
        else if (force_wr) idle_q <= 1'b0;
        else if (e_rise)   idle_q <= rnw;
    end

    // R2
    force_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rnw && e_in) |=> !idle_q);

    // R5
    release_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_q) |-> ($past(e_rise) || !$past(rst_n)));

    // R6
    read_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rnw && idle_q) |=> idle_q);

endmodule

// File: rtl/weh_data_latch.sv
// Module: weh_data_latch
// The write data register. While E is high during a write, it loads
// the processor byte on every clock (transparent at clock granularity).
// While E is low it holds its value, which keeps the captured byte
// steady through the hold extension.
module weh_data_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_in,
    input  logic              rnw,
    input  logic              idle_q,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic load;
    assign load = e_in & (~rnw | ~idle_q);

    // Follow din while open, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // R3
    follow_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_in && !rnw) |=> (dout == $past(din)));

    // R4
    hold_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_in) |=> $stable(dout));

endmodule

// File: rtl/wr_hold_extender.sv
// Module: wr_hold_extender (top)
// Stretches write data hold time on a buffered bus by one E half
// period. Assumes e_clk, rnw and cpu_data are synchronous to clk.
// The external tri-state buffer is driven from bus_data and bus_oe.
module wr_hold_extender #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_clk,
    input  logic              rnw,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              rd_dly,
    output logic              rd_dly_n,
    output logic              wr_dly,
    output logic              wr_dly_n
);
    import weh_pkg::*;

    logic        e_rise;
    logic        idle_q;
    weh_strobe_t strobes;

    weh_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .e_in   (e_clk),
        .e_rise (e_rise)
    );

    weh_delay_ff u_dff (
        .clk    (clk),
        .rst_n  (rst_n),
        .e_in   (e_clk),
        .e_rise (e_rise),
        .rnw    (rnw),
        .idle_q (idle_q)
    );

    weh_data_latch #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .e_in   (e_clk),
        .rnw    (rnw),
        .idle_q (idle_q),
        .din    (cpu_data),
        .dout   (bus_data)
    );

    assign strobes  = weh_make_strobes(idle_q);
    assign bus_oe   = ~idle_q;
    assign rd_dly   = strobes.rd;
    assign rd_dly_n = strobes.rd_n;
    assign wr_dly   = strobes.wr;
    assign wr_dly_n = strobes.wr_n;

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> !bus_oe);

    // R8
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!rd_dly && wr_dly));

endmodule

// File: tb/tb_wr_hold_extender.sv
`timescale 1ns/1ps
module tb_wr_hold_extender;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         e_clk = 1'b0;
    logic         rnw = 1'b1;
    logic [W-1:0] cpu_data = '0;
    logic [W-1:0] bus_data;
    logic         bus_oe, rd_dly, rd_dly_n, wr_dly, wr_dly_n;
    wire  [W-1:0] shared_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic         oe;
        logic [W-1:0] data;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    assign shared_bus = bus_oe ? bus_data : {W{1'bz}};

    wr_hold_extender #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rnw(rnw),
        .cpu_data(cpu_data), .bus_data(bus_data), .bus_oe(bus_oe),
        .rd_dly(rd_dly), .rd_dly_n(rd_dly_n),
        .wr_dly(wr_dly), .wr_dly_n(wr_dly_n)
    );

    // Driver: one clock of stimulus plus the expected state after the edge
    task automatic cyc(input logic r, input logic e, input logic rw,
                       input logic [W-1:0] d, input logic eoe,
                       input logic [W-1:0] edata, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = r; e_clk = e; rnw = rw; cpu_data = d;
        it.oe = eoe; it.data = edata; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic e_low(input logic rw, input logic [W-1:0] d, input int n,
                         input logic eoe, input logic [W-1:0] edata,
                         input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, rw, d, eoe, edata, tag);
    endtask

    task automatic hi_write(input logic [W-1:0] d, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b0, d, 1'b1, d, tag);
    endtask

    task automatic hi_read(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1, '1, 1'b0, '0, tag);
    endtask

    // Monitor: pop one expectation per clock and compare after the edge
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_cmp++;
                if (bus_oe !== it.oe) begin
                    n_bad++;
                    $display("FAIL %s: bus_oe actual %b expected %b", it.tag, bus_oe, it.oe);
                end
                n_cmp++;
                if (it.oe && shared_bus !== it.data) begin
                    n_bad++;
                    $display("FAIL %s: bus actual %h expected %h", it.tag, shared_bus, it.data);
                end else if (!it.oe && shared_bus !== {W{1'bz}}) begin
                    n_bad++;
                    $display("FAIL %s: bus actual %h expected Z", it.tag, shared_bus);
                end
                // R8 strobe polarities
                n_cmp++;
                if ({wr_dly, wr_dly_n, rd_dly, rd_dly_n} !== {it.oe, !it.oe, !it.oe, it.oe}) begin
                    n_bad++;
                    $display("FAIL R8 (%s): strobes actual %b expected %b", it.tag,
                             {wr_dly, wr_dly_n, rd_dly, rd_dly_n},
                             {it.oe, !it.oe, !it.oe, it.oe});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, '0, 1'b0, '0, "R1");

        // R6 read-only cycle never drives
        e_low(1'b1, 12'h111, 3, 1'b0, '0, "R6");
        hi_read(3, "R6");

        // Write, H = 3: byte changes while E high (R2, R3)
        e_low(1'b0, 12'hA5C, 3, 1'b0, '0, "R2");
        hi_write(12'hA5C, 2, "R2");
        hi_write(12'h3F1, 1, "R3");
        // R4/R5 hold through low phase with garbage on cpu_data
        e_low(1'b1, 12'h000, 3, 1'b1, 12'h3F1, "R4");
        hi_read(3, "R5");

        // R7 back-to-back writes, H = 6
        e_low(1'b0, 12'h7E2, 6, 1'b0, '0, "R7");
        hi_write(12'h7E2, 6, "R7");
        e_low(1'b0, 12'hC0D, 6, 1'b1, 12'h7E2, "R7");
        hi_write(12'hC0D, 6, "R7");
        // R5 extension equals a six-clock half period
        e_low(1'b1, 12'hFFF, 6, 1'b1, 12'hC0D, "R5");
        hi_read(6, "R5");

        // R9 reset in the middle of a write, then re-entry
        e_low(1'b0, 12'h5A5, 3, 1'b0, '0, "R9");
        hi_write(12'h5A5, 1, "R9");
        cyc(1'b0, 1'b1, 1'b0, 12'h5A5, 1'b0, '0, "R9");
        hi_write(12'h6B6, 2, "R9");
        e_low(1'b1, 12'h000, 3, 1'b1, 12'h6B6, "R4");
        hi_read(2, "R5");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: leftover actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule